// File: doc/BRIEF.md
# SPI Wiper Command Controller

This block is the serial control front end of a dual-channel digital potentiometer. It holds two 9-bit volatile wiper registers and changes them in response to commands sent by a host over a four-wire serial link in mode 0 (clock idles low, data sampled on the rising edge). The serial pins are oversampled by the block's own clock through a synchronizer. All edge detection and register updates therefore happen in a single clock domain.

A frame is the time the chip select is held low. A frame may contain any number of commands back to back. Each command opens with one byte that holds a target address, an operation code and two spare bits. Increment and decrement are one byte long, and they move the selected wiper by one code, with saturation. Write and read are two bytes long, and they carry a 9-bit value. The serial output answers every bit position. An error flag reports a bad address and mutes the rest of the frame. A parameter chooses 7-bit or 8-bit resolution, which sets the full-scale code and the reset value.

Top module: `wiper_spi_ctrl`

## Requirements
- R1: A command byte arrives MSB first, with SDI sampled on SCK rising edges while CS is low. Bits 7:4 are the address and bits 3:2 the operation: 00 write, 01 increment, 10 decrement, 11 read. Bits 1:0 are ignored, except that bit 0 carries data bit 8 for a write.
- R2: Several commands can follow one another within a single CS-low frame. Each new command byte starts right after the previous command ends: after 8 bits for increment or decrement, and after 16 bits for write or read.
- R3: An increment changes the addressed wiper from n to n+1. The new value appears after the 8th rising SCK edge of the command, and not before it.
- R4: An increment at full scale leaves the wiper unchanged. Full scale is 0x100 when RES_BITS=8 and 0x080 when RES_BITS=7.
- R5: If a wiper holds a value above full scale (0x101 to 0x1FF for 8-bit, above 0x080 for 7-bit), increment and decrement have no effect on it.
- R6: A decrement changes the addressed wiper from n to n-1 and saturates at 0x000.
- R7: A write loads the 9-bit value {command bit 0, following byte} into the addressed wiper after the 16th rising edge of the command.
- R8: SDO changes on SCK falling edges. For a valid increment, decrement or write, SDO is 1 in every bit position of the command. For a read, SDO is 1 in positions 0 to 6, then gives the wiper value MSB first in positions 7 to 15.
- R9: After reset, both wipers hold mid-scale: 0x080 for 8-bit, 0x040 for 7-bit. SDO is high whenever CS is high.
- R10: An address other than 0 or 1 sets an error. SDO is then 0 from bit position 6 of that command until CS rises. Neither that command nor any later command in the same frame is executed. The next frame behaves normally.
- R11: A command whose last bit has not been taken before CS rises is discarded. This includes a CS rise that reaches the block on the same cycle as the last SCK rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, mode 0 |
| spi_cs_n | input | 1 | Chip select, active low, frames the commands |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial data to the host: read data or error indication |
| wiper0 | output | 9 | Current value of wiper register 0 |
| wiper1 | output | 9 | Current value of wiper register 1 |

## Verification
Two events can meet in the same clock cycle: the rising edge that completes a command and the deassertion of chip select. The two share one synchronizer, so both reach the decode logic together. The bench raises CS in the same time step as the final SCK rising edge of an increment. It then checks that the wiper kept its old value, and that a following normal frame still increments it. Saturation meeting a chained command, and an error arriving in the middle of a chained frame, are covered by multi-command frames in the vector table.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    localparam int WIPER_W    = 9;
    localparam int NUM_WIPERS = 2;
    localparam int SEL_W      = (NUM_WIPERS > 1) ? $clog2(NUM_WIPERS) : 1;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_INC   = 2'b01,
        OP_DEC   = 2'b10,
        OP_READ  = 2'b11
    } op_e;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/wiper_step.sv
module wiper_step
    import wiper_pkg::*;
#(
    parameter int RES_BITS = 8
) (
    input  logic [WIPER_W-1:0] cur,
    input  logic               do_inc,
    input  logic               do_dec,
    output logic [WIPER_W-1:0] nxt
);

    localparam logic [WIPER_W-1:0] FULL = WIPER_W'(1 << RES_BITS);

    // Values above full scale are frozen for both directions.
    always_comb begin
        nxt = cur;
        if (do_inc && (cur < FULL)) begin
            nxt = cur + WIPER_W'(1);
        end else if (do_dec && (cur != '0) && (cur <= FULL)) begin
            nxt = cur - WIPER_W'(1);
        end
    end

endmodule

// File: rtl/wiper_spi_ctrl.sv
module wiper_spi_ctrl
    import wiper_pkg::*;
#(
    parameter int RES_BITS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sck,
    input  logic               spi_cs_n,
    input  logic               spi_sdi,
    output logic               spi_sdo,
    output logic [WIPER_W-1:0] wiper0,
    output logic [WIPER_W-1:0] wiper1
);

    localparam logic [WIPER_W-1:0] FULL     = WIPER_W'(1 << RES_BITS);
    localparam logic [WIPER_W-1:0] MID      = FULL >> 1;
    localparam int                 CNT_W    = 4;
    localparam logic [CNT_W-1:0]   POS_DEC  = CNT_W'(5);
    localparam logic [CNT_W-1:0]   POS_ERR  = CNT_W'(6);
    localparam logic [CNT_W-1:0]   POS_LAST = CNT_W'(7);
    localparam logic [CNT_W-1:0]   POS_END  = CNT_W'(15);

    typedef struct packed {
        logic [CNT_W-1:0]                      bit_cnt;
        logic [6:0]                            shreg;
        logic [SEL_W-1:0]                      sel;
        op_e                                   op;
        logic                                  d8;
        logic                                  err_n;
        logic                                  sdo;
        logic                                  sck_prev;
        logic [NUM_WIPERS-1:0][WIPER_W-1:0]    wiper;
    } state_t;

    state_t q, d;

    // Pin synchronizer: {sck, cs_n, sdi}, cs_n resets inactive.
    logic [2:0] pins_async, pins_sync;
    assign pins_async = {spi_sck, spi_cs_n, spi_sdi};

    spi_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_async),
        .dout (pins_sync)
    );

    logic sck_s, cs_act, sdi_s, sck_rise, sck_fall;
    assign sck_s    = pins_sync[2];
    assign cs_act   = ~pins_sync[1];
    assign sdi_s    = pins_sync[0];
    assign sck_rise = sck_s & ~q.sck_prev;
    assign sck_fall = ~sck_s & q.sck_prev;

    // Command decode and execution strobes.
    logic [7:0]         shifted;
    logic [3:0]         cmd_addr;
    op_e                cmd_op;
    logic               addr_ok;
    logic               take_bit;
    logic               exec_inc, exec_dec, exec_wr;
    logic [WIPER_W-1:0] wdata;
    logic [WIPER_W-1:0] rd_word;
    logic [CNT_W-1:0]   rd_idx;
    logic               sdo_next;
    logic               err_n_q;

    always_comb begin
        shifted  = {q.shreg, sdi_s};
        cmd_addr = shifted[5:2];
        cmd_op   = op_e'(shifted[1:0]);
        addr_ok  = (cmd_addr < 4'(NUM_WIPERS));
        take_bit = cs_act && sck_rise && q.err_n;
        exec_inc = take_bit && (q.bit_cnt == POS_LAST) && (q.op == OP_INC);
        exec_dec = take_bit && (q.bit_cnt == POS_LAST) && (q.op == OP_DEC);
        exec_wr  = take_bit && (q.bit_cnt == POS_END) && (q.op == OP_WRITE);
        wdata    = {q.d8, shifted};
        rd_word  = q.wiper[q.sel];
        rd_idx   = POS_END - q.bit_cnt;
        err_n_q  = q.err_n;
    end

    // Bit to present on the next falling edge, for the position now pending.
    always_comb begin
        if (!q.err_n) begin
            sdo_next = 1'b0;
        end else if ((q.op == OP_READ) && (q.bit_cnt == POS_LAST)) begin
            sdo_next = rd_word[WIPER_W-1];
        end else if ((q.op == OP_READ) && (q.bit_cnt > POS_LAST)) begin
            sdo_next = rd_word[rd_idx];
        end else begin
            sdo_next = 1'b1;
        end
    end

    logic [NUM_WIPERS-1:0][WIPER_W-1:0] step_nxt;

    for (genvar i = 0; i < NUM_WIPERS; i++) begin : g_step
        wiper_step #(
            .RES_BITS(RES_BITS)
        ) u_step (
            .cur   (q.wiper[i]),
            .do_inc(exec_inc && (q.sel == SEL_W'(i))),
            .do_dec(exec_dec && (q.sel == SEL_W'(i))),
            .nxt   (step_nxt[i])
        );
    end

    always_comb begin
        d          = q;
        d.sck_prev = sck_s;
        if (!cs_act) begin
            d.bit_cnt = '0;
            d.err_n   = 1'b1;
            d.sdo     = 1'b1;
        end else begin
            if (sck_rise) begin
                d.shreg   = shifted[6:0];
                d.bit_cnt = q.bit_cnt + CNT_W'(1);
                if ((q.bit_cnt == POS_DEC) && q.err_n) begin
                    d.sel = cmd_addr[SEL_W-1:0];
                    d.op  = cmd_op;
                    if (!addr_ok) begin
                        d.err_n = 1'b0;
                    end
                end
                if (q.bit_cnt == POS_LAST) begin
                    d.d8 = sdi_s;
                    if (!q.err_n || (q.op == OP_INC) || (q.op == OP_DEC)) begin
                        d.bit_cnt = '0;
                    end
                end
            end
            if (sck_fall) begin
                d.sdo = sdo_next;
            end
        end
        for (int i = 0; i < NUM_WIPERS; i++) begin
            d.wiper[i] = step_nxt[i];
            if (exec_wr && (q.sel == SEL_W'(i))) begin
                d.wiper[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.bit_cnt  <= '0;
            q.shreg    <= '0;
            q.sel      <= '0;
            q.op       <= OP_WRITE;
            q.d8       <= 1'b0;
            q.err_n    <= 1'b1;
            q.sdo      <= 1'b1;
            q.sck_prev <= 1'b0;
            q.wiper    <= {NUM_WIPERS{MID}};
        end else begin
            q <= d;
        end
    end

    assign spi_sdo = q.sdo;
    assign wiper0  = q.wiper[0];
    assign wiper1  = q.wiper[1];

    // POS_ERR documents where the error bit first appears on SDO.
    localparam int ERR_POS_CHECK = int'(POS_ERR);

endmodule

// File: rtl/wiper_spi_chk.sv
module wiper_spi_chk
    import wiper_pkg::*;
#(
    parameter int RES_BITS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_act,
    input logic               sck_fall,
    input logic               err_n,
    input logic               exec_inc,
    input logic               exec_dec,
    input logic               exec_wr,
    input logic               spi_sdo,
    input logic [WIPER_W-1:0] wiper0,
    input logic [WIPER_W-1:0] wiper1,
    input logic               sel
);

    localparam logic [WIPER_W-1:0] FULL = WIPER_W'(1 << RES_BITS);

    p_inc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        exec_inc && !sel && (wiper0 < FULL) |=> wiper0 == $past(wiper0) + WIPER_W'(1));

    p_inc_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exec_inc && !sel && (wiper0 == FULL) |=> wiper0 == FULL);

    p_oor_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_inc || exec_dec) && !sel && (wiper0 > FULL) |=> $stable(wiper0));

    p_dec_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exec_dec && sel && (wiper1 == '0) |=> wiper1 == '0);

    p_idle_sdo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> spi_sdo);

    p_err_mute_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_act && !err_n && sck_fall |=> !spi_sdo);

    p_err_noexec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !err_n |-> !(exec_inc || exec_dec || exec_wr));

    p_no_exec_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_inc || exec_dec || exec_wr) |=> $stable(wiper0) && $stable(wiper1));

endmodule

bind wiper_spi_ctrl wiper_spi_chk #(
    .RES_BITS(RES_BITS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_act  (cs_act),
    .sck_fall(sck_fall),
    .err_n   (err_n_q),
    .exec_inc(exec_inc),
    .exec_dec(exec_dec),
    .exec_wr (exec_wr),
    .spi_sdo (spi_sdo),
    .wiper0  (wiper0),
    .wiper1  (wiper1),
    .sel     (q.sel[0])
);

// File: tb/tb_wiper_spi_ctrl.sv
module tb_wiper_spi_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       sdi = 1'b0;
    logic       sdo, sdo7;
    logic [8:0] w0, w1, w0_7, w1_7;
    int         n_chk = 0;
    int         n_fail = 0;
    logic       done = 1'b0;

    always #4 clk = ~clk;

    wiper_spi_ctrl #(.RES_BITS(8)) dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_sdi(sdi),
        .spi_sdo(sdo), .wiper0(w0), .wiper1(w1));

    wiper_spi_ctrl #(.RES_BITS(7)) dut_r7 (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_sdi(sdi),
        .spi_sdo(sdo7), .wiper0(w0_7), .wiper1(w1_7));

    typedef struct packed {
        logic [31:0] mosi;
        logic [5:0]  nbits;
        logic [8:0]  w0;
        logic [8:0]  w1;
        logic [31:0] miso;
    } vec_t;

    // Frames left-aligned; expected wipers for the 8-bit instance.
    localparam vec_t VECS [0:14] = '{
        '{32'h04000000, 6'd8,  9'h081, 9'h080, 32'hFF000000},  // R1 inc w0
        '{32'h04041400, 6'd24, 9'h083, 9'h081, 32'hFFFFFF00},  // R2 chained
        '{32'h18000000, 6'd8,  9'h083, 9'h080, 32'hFF000000},  // R6 dec w1
        '{32'h00FF0000, 6'd16, 9'h0FF, 9'h080, 32'hFFFF0000},  // R7 write w0
        '{32'h04040000, 6'd16, 9'h100, 9'h080, 32'hFFFF0000},  // R4 saturate
        '{32'h0C000000, 6'd16, 9'h100, 9'h080, 32'hFF000000},  // R8 read w0
        '{32'h11A50000, 6'd16, 9'h100, 9'h1A5, 32'hFFFF0000},  // R7 write w1
        '{32'h14180000, 6'd16, 9'h100, 9'h1A5, 32'hFFFF0000},  // R5 frozen
        '{32'h1C000000, 6'd16, 9'h100, 9'h1A5, 32'hFFA50000},  // R8 read w1
        '{32'h10011818, 6'd32, 9'h100, 9'h000, 32'hFFFFFFFF},  // R6 floor
        '{32'h24080000, 6'd16, 9'h100, 9'h000, 32'hFC000000},  // R10 error
        '{32'h08300800, 6'd24, 9'h0FF, 9'h000, 32'hFFFC0000},  // R10 mid-frame
        '{32'h08000000, 6'd8,  9'h0FE, 9'h000, 32'hFF000000},  // R10 recovery
        '{32'h04000000, 6'd7,  9'h0FE, 9'h000, 32'hFE000000},  // R11 partial
        '{32'h00F00000, 6'd12, 9'h0FE, 9'h000, 32'hFFF00000}   // R11 partial
    };

    string vreq [0:14] = '{"R1", "R2", "R6", "R7", "R4", "R8", "R7", "R5",
                           "R8", "R6", "R10", "R10", "R10", "R11", "R11"};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic spi_bit(input logic b, output logic so);
        sdi = b;
        repeat (HALF) @(negedge clk);
        so  = sdo;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic frame(input logic [31:0] mosi, input int nbits, output logic [31:0] miso);
        logic so;
        miso = '0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_bit(mosi[31-i], so);
            miso[31-i] = so;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] miso;
        logic [31:0] mask;
        logic        so;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 reset w0", 32'(w0), 32'h080);
        chk("R9 reset w1", 32'(w1), 32'h080);
        chk("R9 idle sdo", 32'(sdo), 32'h1);

        for (int v = 0; v < 15; v++) begin
            frame(VECS[v].mosi, int'(VECS[v].nbits), miso);
            mask = ~(32'hFFFFFFFF >> VECS[v].nbits);
            chk({vreq[v], " w0"}, 32'(w0), 32'(VECS[v].w0));
            chk({vreq[v], " w1"}, 32'(w1), 32'(VECS[v].w1));
            chk({vreq[v], " sdo"}, miso & mask, VECS[v].miso & mask);
        end

        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 reset 7-bit w0", 32'(w0_7), 32'h040);
        chk("R9 reset 7-bit w1", 32'(w1_7), 32'h040);
        chk("R9 reset 7-bit sdo", 32'(sdo7), 32'h1);
        chk("R9 reset w0 again", 32'(w0), 32'h080);

        // R3 and R1: byte 0x07 (spare bits set) increments at the 8th edge only
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 7; i > 0; i--) spi_bit(1'((8'h07 >> i) & 8'h1), so);
        chk("R3 before 8th edge", 32'(w0), 32'h080);
        spi_bit(1'b1, so);
        chk("R3 after 8th edge", 32'(w0), 32'h081);
        chk("R1 spare bits ignored 7-bit", 32'(w0_7), 32'h041);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);

        // R4 7-bit: write 0x07F, two increments -> 0x080
        frame(32'h007F0404, 32, miso);
        chk("R4 7-bit full scale", 32'(w0_7), 32'h080);
        chk("R4 8-bit passes 0x080", 32'(w0), 32'h081);

        // R5 7-bit: 0x0C0 is above full scale
        frame(32'h00C00400, 24, miso);
        chk("R5 7-bit inc frozen", 32'(w0_7), 32'h0C0);
        chk("R5 8-bit inc active", 32'(w0), 32'h0C1);
        frame(32'h08000000, 8, miso);
        chk("R5 7-bit dec frozen", 32'(w0_7), 32'h0C0);
        chk("R6 8-bit dec", 32'(w0), 32'h0C0);

        // R11: CS rises together with the last rising edge of an increment
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 7; i > 0; i--) spi_bit(1'((8'h14 >> i) & 8'h1), so);
        sdi = 1'b0;
        repeat (HALF) @(negedge clk);
        sck  = 1'b1;
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
        sck = 1'b0;
        repeat (2 * HALF) @(negedge clk);
        chk("R11 collision w1", 32'(w1), 32'h080);
        chk("R11 collision 7-bit w1", 32'(w1_7), 32'h040);
        frame(32'h14000000, 8, miso);
        chk("R11 next frame works", 32'(w1), 32'h081);
        chk("R3 7-bit inc w1", 32'(w1_7), 32'h041);
        chk("R9 sdo high after frame", 32'(sdo), 32'h1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule